// File: doc/BRIEF.md
# Interleaved Multi-Phase PWM Timing Generator

This block produces the gate-timing levels for a multi-phase buck converter with two or three channels running from one shared clock. A master counter sets the switching cycle, whose length in clock ticks is a programmable count. Each channel has its own termination point, spaced evenly around that cycle. At that point the channel's pulse ends, and its private ramp counter starts again. After a mandatory low interval of a quarter cycle, each channel rises when its ramp reaches that channel's compare level. The compare level comes from an upstream regulation loop and has already been corrected.

The cycle starts when channel 1's pulse ends. In three-phase mode, channels 2 and 3 end their pulses one third and two thirds of a cycle later. A strap input selects two-phase mode, which puts channel 2 half a cycle after channel 1 and parks channel 3. A one-tick strobe marks every channel-1 termination, so that reference stepping and sequencing logic can align to the cycle. Per-channel output enables stand for the high-impedance state of the drive lines.

Top module: `interleaved_pwm_gen`

## Requirements
- R1: `cycleStrobe` is high for exactly one tick. It first rises two edges after `runEn` is first seen high, and then recurs every P ticks, where P is the effective period. `pwmOut[0]` is low in every tick in which the strobe is high.
- R2: In three-phase mode (`twoPhaseStrap` = 0), the ticks are numbered s = 0 at a strobe. Channel 2 terminates at s = floor(P/3) and channel 3 at s = 2*floor(P/3), so channel 3 absorbs the remainder.
- R3: In two-phase mode (`twoPhaseStrap` = 1), channel 2 terminates at s = floor(P/2). Channel 3 has `pwmOe[2]` = 0 and `pwmOut[2]` = 0.
- R4: For u ticks after its own termination (u = 0 is the tick that follows the ending edge), a channel is low for every u < ceil(P/4). As a result, each channel is high for no more than P - ceil(P/4) ticks of each cycle.
- R5: A running, armed channel is high exactly when u >= max(compare level, ceil(P/4)). A compare level of P or more gives zero duty. Each channel's compare level is the 12-bit field `cmpLevel[12k+11:12k]` for channel index k = 0, 1, 2.
- R6: After an edge at which `runEn` is low, all of `pwmOe`, `pwmOut` and `cycleStrobe` are 0. A later start begins again from s = 0.
- R7: After a start, a channel stays low until its own first termination has passed.
- R8: A `periodCnt` below 4 is treated as a period of 4.
- R9: While reset is held, `pwmOut`, `pwmOe` and `cycleStrobe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Run enable |
| periodCnt | input | CNT_W | Switching period in ticks, sampled at cycle boundaries |
| twoPhaseStrap | input | 1 | 1 selects two-phase spacing, sampled at cycle boundaries |
| cmpLevel | input | 3*CNT_W | Per-channel compare levels, channel k in field k |
| pwmOut | output | 3 | PWM levels, bit k for channel k+1 |
| pwmOe | output | 3 | Per-channel output enables, 0 meaning high impedance |
| cycleStrobe | output | 1 | One-tick strobe at each channel-1 termination |

## Verification
`runEn` is driven on a falling edge. The enables follow at the next rising edge, and the first strobe follows one rising edge after that, so the bench samples each one on the matching falling edge. From the strobe onward, the bench counts ticks s. For each channel it computes the tick position u from the offsets above, and then the expected level for every tick over four cycles. This covers the unarmed first window as well as steady state. A stop is checked one edge after `runEn` falls. The configurations cover both modes, remainder periods, the clamp below 4, and a sweep of compare levels across the blanking and zero-duty limits.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  localparam int ILV_CH_N = 3;

  // Strobes passed from the phase controller to the channel datapath.
  typedef struct packed {
    logic                halt;     // run enable is low this tick
    logic [ILV_CH_N-1:0] chanOn;   // channel is driven (output enable)
    logic [ILV_CH_N-1:0] termStb;  // channel terminates at this edge
  } ilvStrb_t;

endpackage

// File: rtl/ilv_phase_ctrl.sv
module ilv_phase_ctrl
  import ilv_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int MIN_PERIOD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             runEn,
  input  logic [CNT_W-1:0] periodCnt,
  input  logic             twoPhaseStrap,
  output ilvStrb_t         strb,
  output logic [CNT_W-1:0] blankLen,
  output logic             cycleStrobe
);

  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PERIOD);
  localparam logic [CNT_W-1:0] THREE = CNT_W'(3);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic             active;
  logic [CNT_W-1:0] masterCnt;
  logic [CNT_W-1:0] curPeriod;
  logic             twoQ;
  logic             strobeQ;

  logic [CNT_W-1:0] reqPeriod;
  logic [CNT_W-1:0] thirdOff;
  logic [CNT_W-1:0] halfOff;
  logic [CNT_W-1:0] off2;
  logic [CNT_W-1:0] off3;
  logic             wrapNow;

  // Clamp the requested period so that the quarter window is never empty.
  assign reqPeriod = (periodCnt < MIN_P) ? MIN_P : periodCnt;

  // Phase offsets are derived from the period that is latched for this cycle.
  assign thirdOff = curPeriod / THREE;
  assign halfOff  = curPeriod >> 1;
  assign off2     = twoQ ? halfOff : thirdOff;
  assign off3     = {thirdOff[CNT_W-2:0], 1'b0};
  assign wrapNow  = (masterCnt == (curPeriod - ONE));

  // The blanking length is ceil(period/4), computed without overflow.
  assign blankLen = (curPeriod >> 2) + {{(CNT_W-1){1'b0}}, |curPeriod[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      masterCnt <= '0;
      curPeriod <= MIN_P;
      twoQ      <= 1'b0;
      strobeQ   <= 1'b0;
    end else if (!runEn) begin
      active    <= 1'b0;
      masterCnt <= '0;
      curPeriod <= reqPeriod;
      twoQ      <= twoPhaseStrap;
      strobeQ   <= 1'b0;
    end else begin
      active  <= 1'b1;
      strobeQ <= active && (masterCnt == '0);
      if (!active) begin
        masterCnt <= '0;
        curPeriod <= reqPeriod;
        twoQ      <= twoPhaseStrap;
      end else if (wrapNow) begin
        masterCnt <= '0;
        curPeriod <= reqPeriod;
        twoQ      <= twoPhaseStrap;
      end else begin
        masterCnt <= masterCnt + ONE;
      end
    end
  end

  always_comb begin
    strb.halt       = !runEn;
    strb.termStb[0] = active && (masterCnt == '0);
    strb.termStb[1] = active && (masterCnt == off2);
    strb.termStb[2] = active && !twoQ && (masterCnt == off3);
    strb.chanOn[0]  = active;
    strb.chanOn[1]  = active;
    strb.chanOn[2]  = active && !twoQ;
  end

  assign cycleStrobe = strobeQ;

endmodule

// File: rtl/ilv_pwm_datapath.sv
module ilv_pwm_datapath
  import ilv_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  ilvStrb_t                  strb,
  input  logic [CNT_W-1:0]          blankLen,
  input  logic [ILV_CH_N*CNT_W-1:0] cmpLevel,
  output logic [ILV_CH_N-1:0]       pwmLvl
);

  localparam logic [CNT_W-1:0] SAW_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  for (genvar ch = 0; ch < ILV_CH_N; ch++) begin : g_chan
    logic [CNT_W-1:0] saw;
    logic [CNT_W-1:0] sawNext;
    logic [CNT_W-1:0] cmpCh;
    logic [CNT_W-1:0] thresh;
    logic             armed;
    logic             pwmQ;

    assign cmpCh   = cmpLevel[ch*CNT_W +: CNT_W];
    // The rising point is never allowed inside the forced-low window.
    assign thresh  = (cmpCh > blankLen) ? cmpCh : blankLen;
    assign sawNext = (saw == SAW_MAX) ? saw : saw + ONE;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        saw   <= '0;
        armed <= 1'b0;
        pwmQ  <= 1'b0;
      end else if (strb.halt || !strb.chanOn[ch]) begin
        saw   <= '0;
        armed <= 1'b0;
        pwmQ  <= 1'b0;
      end else if (strb.termStb[ch]) begin
        saw   <= '0;
        armed <= 1'b1;
        pwmQ  <= 1'b0;
      end else begin
        saw   <= sawNext;
        pwmQ  <= armed && (sawNext >= thresh);
      end
    end

    assign pwmLvl[ch] = pwmQ;
  end

endmodule

// File: rtl/interleaved_pwm_gen.sv
module interleaved_pwm_gen
  import ilv_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int MIN_PERIOD = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      runEn,
  input  logic [CNT_W-1:0]          periodCnt,
  input  logic                      twoPhaseStrap,
  input  logic [ILV_CH_N*CNT_W-1:0] cmpLevel,
  output logic [ILV_CH_N-1:0]       pwmOut,
  output logic [ILV_CH_N-1:0]       pwmOe,
  output logic                      cycleStrobe
);

  ilvStrb_t         strb;
  logic [CNT_W-1:0] blankLen;

  ilv_phase_ctrl #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .runEn        (runEn),
    .periodCnt    (periodCnt),
    .twoPhaseStrap(twoPhaseStrap),
    .strb         (strb),
    .blankLen     (blankLen),
    .cycleStrobe  (cycleStrobe)
  );

  ilv_pwm_datapath #(.CNT_W(CNT_W)) u_path (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .blankLen(blankLen),
    .cmpLevel(cmpLevel),
    .pwmLvl  (pwmOut)
  );

  assign pwmOe = strb.chanOn;

endmodule

// File: rtl/ilv_pwm_checker.sv
module ilv_pwm_checker #(
  parameter int CH_N = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            runEn,
  input logic [CH_N-1:0] pwmOut,
  input logic [CH_N-1:0] pwmOe,
  input logic            cycleStrobe
);

  // R1: channel 1 is low whenever the cycle strobe is high
  p_strobe_ch1_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cycleStrobe |-> !pwmOut[0]);

  // R1: the strobe lasts a single tick
  p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cycleStrobe |=> !cycleStrobe);

  // R6: a low run enable clears every output at the next edge
  p_stop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !runEn |=> (pwmOe == '0 && pwmOut == '0 && !cycleStrobe));

  // R6: a channel whose enable is off never drives high
  p_oe_gates_pwm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwmOut & ~pwmOe) == '0);

  // R7: a rising output needs the channel to have been enabled already
  p_rise_after_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwmOut & ~$past(pwmOut)) & ~$past(pwmOe)) == '0);

endmodule

bind interleaved_pwm_gen ilv_pwm_checker #(.CH_N(ilv_pkg::ILV_CH_N)) u_check (
  .clk        (clk),
  .rst_n      (rst_n),
  .runEn      (runEn),
  .pwmOut     (pwmOut),
  .pwmOe      (pwmOe),
  .cycleStrobe(cycleStrobe)
);

// File: tb/interleaved_pwm_gen_test.sv
module interleaved_pwm_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 12;
  localparam int WATCHDOG   = 100000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             runEn = 1'b0;
  logic [CNT_W-1:0] periodCnt = '0;
  logic             twoPhaseStrap = 1'b0;
  logic [3*CNT_W-1:0] cmpLevel = '0;
  logic [2:0]       pwmOut;
  logic [2:0]       pwmOe;
  logic             cycleStrobe;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interleaved_pwm_gen #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .runEn(runEn), .periodCnt(periodCnt),
    .twoPhaseStrap(twoPhaseStrap), .cmpLevel(cmpLevel),
    .pwmOut(pwmOut), .pwmOe(pwmOe), .cycleStrobe(cycleStrobe)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Run one configuration for four cycles, then stop and check the stop.
  task automatic runCfg(input int p, input bit two, input int c0, input int c1, input int c2);
    int pe, q, offs[3], thr[3], highs[3], cmps[3];
    pe = (p < 4) ? 4 : p;
    q  = (pe + 3) / 4;
    cmps[0] = c0; cmps[1] = c1; cmps[2] = c2;
    offs[0] = 0;
    offs[1] = two ? pe / 2 : pe / 3;
    offs[2] = 2 * (pe / 3);
    for (int k = 0; k < 3; k++) begin
      thr[k] = (cmps[k] > q) ? cmps[k] : q;
      highs[k] = 0;
    end
    @(negedge clk);
    periodCnt = CNT_W'(p);
    twoPhaseStrap = two;
    cmpLevel = {CNT_W'(c2), CNT_W'(c1), CNT_W'(c0)};
    runEn = 1'b1;
    @(negedge clk);
    check("R1 strobe before first termination", int'(cycleStrobe), 0);
    check(two ? "R3 enables" : "R2 enables", int'(pwmOe), two ? 3 : 7);
    check("R7 outputs low at start", int'(pwmOut), 0);
    @(negedge clk);
    for (int s = 0; s < 4 * pe; s++) begin
      if (s > 0) @(negedge clk);
      check("R1 strobe position", int'(cycleStrobe), (s % pe == 0) ? 1 : 0);
      for (int k = 0; k < 3; k++) begin
        int u, exp;
        string tag;
        u = (s >= offs[k]) ? (s - offs[k]) % pe : 0;
        if (two && k == 2)        begin exp = 0; tag = "R3 channel 3 parked"; end
        else if (s < offs[k])     begin exp = 0; tag = "R7 before first termination"; end
        else begin
          exp = (u >= thr[k]) ? 1 : 0;
          if (p < 4)                  tag = "R8 clamped period";
          else if (u == 0 && k > 0)   tag = two ? "R3 channel 2 offset" : "R2 channel offset";
          else if (u < q)             tag = "R4 forced low";
          else                        tag = "R5 compare crossing";
        end
        check(tag, int'(pwmOut[k]), exp);
        if (s >= pe && s < 2 * pe) highs[k] += int'(pwmOut[k]);
      end
    end
    for (int k = 0; k < 3; k++) begin
      int expH;
      expH = (two && k == 2) ? 0 : ((thr[k] < pe) ? pe - thr[k] : 0);
      check("R4 high ticks per cycle", highs[k], expH);
    end
    @(negedge clk);
    runEn = 1'b0;
    @(negedge clk);
    check("R6 enables after stop", int'(pwmOe), 0);
    check("R6 outputs after stop", int'(pwmOut), 0);
    check("R6 strobe after stop", int'(cycleStrobe), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    runEn = 1'b1;
    periodCnt = 12'd12;
    repeat (3) @(negedge clk);
    check("R9 outputs in reset", int'(pwmOut), 0);
    check("R9 enables in reset", int'(pwmOe), 0);
    check("R9 strobe in reset", int'(cycleStrobe), 0);
    runEn = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 idle enables", int'(pwmOe), 0);

    runCfg(12, 1'b0, 0, 0, 0);
    runCfg(13, 1'b0, 5, 9, 20);
    runCfg(12, 1'b1, 4, 7, 0);
    runCfg(13, 1'b1, 2, 12, 1);
    runCfg(16, 1'b1, 16, 2, 3);
    runCfg(7,  1'b0, 6, 1, 2);
    runCfg(2,  1'b0, 0, 0, 3);
    runCfg(3,  1'b1, 1, 2, 0);
    for (int i = 0; i < 10; i++) runCfg(8, 1'b0, i, i, i);
    for (int i = 0; i < 12; i++) runCfg(10, 1'b1, i, 11 - i, i);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule